// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is the device end of a three-wire serial EEPROM with 2 Kbit of storage, written as synthesizable logic that runs from a system clock. A host selects it with `cs`, shifts commands in on `di` with the serial clock `sk`, and gets read data and programming status back on `do_o`. `do_oe` tells the pad when to drive; while it is low the pad is high impedance. The `org` input picks the organization while the block runs. High gives 128 words of 16 bits and low gives 256 bytes. A board pull-up makes high the default. The storage is a flop array, not nonvolatile cells.

Every command starts with a 1 start bit, then a two-bit opcode, then an address field. Reads put out one dummy zero and then stream words for as long as the clock keeps running. Programming commands (write, erase, write-all, erase-all) run for a fixed number of system clocks with no further serial clocking. The host polls for completion by toggling `cs`. After reset, programming is locked until an enable command arrives.

The control is one state machine:
- States: `ST_IDLE` (wait for a start bit), `ST_HDR` (opcode and address), `ST_DATA` (write data), `ST_READ` (shift out), `ST_HOLD` (command finished or refused, wait for `cs` low), `ST_PROG` (timed programming), `ST_READY` (programming done, status shown).
- Transitions:
  - `ST_IDLE`→`ST_HDR` and `ST_READY`→`ST_HDR` on a start bit.
  - `ST_HDR`→`ST_READ` on a read.
  - `ST_HDR`→`ST_DATA` on a write or write-all.
  - `ST_HDR`→`ST_PROG` on an erase or erase-all when unlocked.
  - `ST_HDR`→`ST_HOLD` on enable, on disable, or on a locked erase.
  - `ST_DATA`→`ST_PROG` when unlocked, or →`ST_HOLD` when locked, once the last data bit is in.
  - `ST_PROG`→`ST_READY` when the timer ends.
  - `cs` low sends `ST_HDR`, `ST_DATA`, `ST_READ` and `ST_HOLD` back to `ST_IDLE`.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `do_oe` is 0, programming is locked, and every byte of the array holds 0xFF.
- R2: A command is a 1 start bit, a two-bit opcode (read 10, write 01, erase 11, extended 00) and an address field, all sent MSB first on rising `sk`. Zeros sampled before the start bit are ignored.
- R3: With `org`=1 the address field is 8 bits and its top bit is ignored (128 words of 16 bits). With `org`=0 it is 9 bits and its top bit is ignored (256 bytes). Word w is made of byte 2w as its upper half and byte 2w+1 as its lower half.
- R4: After the last address bit of a read, `do_oe` rises with `do_o`=0 as a dummy bit. Each following rising `sk` presents the next data bit, MSB first.
- R5: If `sk` keeps running after the last bit of a read word, the next address follows with no dummy bit. The address wraps from the top location to 0 in both organizations.
- R6: Write replaces the whole addressed location with the new data, with no erase needed first.
- R7: Erase sets the addressed location to all ones.
- R8: For the extended opcode, the two top address bits select the command: 00 disable, 01 write-all, 10 erase-all, 11 enable. Write-all loads every location with the data, and erase-all sets every location to all ones.
- R9: While locked, write, erase, write-all and erase-all change nothing and start no busy period. Enable unlocks and disable locks again.
- R10: Programming lasts `WR_CYCLES` system clocks once the last bit is in. After `cs` goes low and then high, `do_o` shows 0 while busy and 1 once done.
- R11: `cs` low releases `do_o` at once and drops a partly received command without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command and data input |
| org | input | 1 | 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data and status output |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
A rising `sk` is seen at the first `clk` edge where it is high, and the state and `do_o` change at that same edge. The bench therefore drives every `sk` phase for three clocks and samples outputs at the third falling edge after the rise, which is well after they have settled. A programming command keeps `do_o` at 0 for `WR_CYCLES` clocks and then spends one clock on the array update. The bench checks busy a few clocks after the `cs` toggle and ready 80 clocks later, and its ready polling stops after a fixed bound. Read data is checked bit by bit against expected words worked out from the command sequence, starting with the dummy bit.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_HOLD,
        ST_PROG,
        ST_READY
    } mw_state_t;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_t;

    typedef enum logic [1:0] {
        EX_LOCK  = 2'b00,
        EX_FILL  = 2'b01,
        EX_CLEAR = 2'b10,
        EX_OPEN  = 2'b11
    } mw_ext_t;

    typedef enum logic [1:0] {
        PG_WRITE,
        PG_ERASE,
        PG_FILL,
        PG_CLEAR
    } mw_prog_t;

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic rise
);
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign rise = sk & ~sk_q;
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            left_q <= '0;
        else if (start)        left_q <= TW'(CYCLES);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_eeprom_pkg::*;
#(
    parameter int BYTES = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  mw_prog_t                  kind,
    input  logic                      x16,
    input  logic [$clog2(BYTES)-1:0]  waddr,
    input  logic [15:0]               wdata,
    input  logic [$clog2(BYTES)-1:0]  raddr,
    output logic [15:0]               rdata
);
    localparam int BA = $clog2(BYTES);

    logic [BYTES*8-1:0] flat;
    logic [BA-1:0]      even_i;

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        localparam logic [BA-1:0] IDX = BA'(g);
        logic       hit;
        logic [7:0] val;
        logic [7:0] q;

        assign hit = x16 ? (IDX[BA-1:1] == waddr[BA-2:0]) : (IDX == waddr);
        assign val = (x16 && !IDX[0]) ? wdata[15:8] : wdata[7:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 8'hFF;
            end else if (commit) begin
                unique case (kind)
                    PG_WRITE: if (hit) q <= val;
                    PG_ERASE: if (hit) q <= 8'hFF;
                    PG_FILL:  q <= val;
                    PG_CLEAR: q <= 8'hFF;
                endcase
            end
        end

        assign flat[g*8 +: 8] = q;
    end

    assign even_i = {raddr[BA-2:0], 1'b0};
    assign rdata  = x16 ? {flat[int'(even_i)*8 +: 8], flat[(int'(even_i)+1)*8 +: 8]}
                        : {8'h00, flat[int'(raddr)*8 +: 8]};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int BYTES     = 256,
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic do_o,
    output logic do_oe
);
    localparam int BA = $clog2(BYTES);
    localparam int HW = BA + 3;
    localparam int DW = 16;
    localparam int CW = $clog2(DW + HW + 1);
    localparam logic [BA-1:0] WORD_MASK = {1'b0, {(BA-1){1'b1}}};

    mw_state_t state, nxt;
    mw_op_t    hdr_op;
    mw_ext_t   hdr_ext;
    mw_prog_t  hdr_kind, pkind;

    logic          x16, sk_rise, prog_busy, prog_start, commit;
    logic          wen_q, poll_q, dummy_q, hdr_done, dat_done;
    logic [HW-1:0] hdr_q, hdr_nx;
    logic [CW-1:0] cnt_q, hdr_last, dat_last;
    logic [DW-1:0] wdat_q, sr_q, rdata, rd_align;
    logic [BA-1:0] uaddr_q, cur_q, cur_nx, hdr_uaddr, rd_addr;

    assign x16 = org;

    mw_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sk   (sk),
        .rise (sk_rise)
    );

    mw_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(prog_start),
        .busy (prog_busy)
    );

    mw_array #(.BYTES(BYTES)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .kind  (pkind),
        .x16   (x16),
        .waddr (uaddr_q),
        .wdata (wdat_q),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    // header decode on the value that includes the bit arriving now
    assign hdr_nx    = {hdr_q[HW-2:0], di};
    assign hdr_op    = mw_op_t'(x16 ? hdr_nx[BA+1:BA] : hdr_nx[BA+2:BA+1]);
    assign hdr_ext   = mw_ext_t'(x16 ? hdr_nx[BA-1:BA-2] : hdr_nx[BA:BA-1]);
    assign hdr_uaddr = x16 ? (hdr_nx[BA-1:0] & WORD_MASK) : hdr_nx[BA-1:0];
    assign hdr_last  = x16 ? CW'(BA + 1) : CW'(BA + 2);
    assign dat_last  = x16 ? CW'(DW - 1) : CW'(7);
    assign hdr_done  = sk_rise && (cnt_q == hdr_last);
    assign dat_done  = sk_rise && (cnt_q == dat_last);

    assign cur_nx   = x16 ? ((cur_q + 1'b1) & WORD_MASK) : (cur_q + 1'b1);
    assign rd_addr  = (state == ST_READ) ? cur_nx : hdr_uaddr;
    assign rd_align = x16 ? rdata : {rdata[7:0], 8'h00};

    always_comb begin
        hdr_kind = PG_WRITE;
        if (hdr_op == OP_ERASE)    hdr_kind = PG_ERASE;
        else if (hdr_op == OP_EXT) hdr_kind = (hdr_ext == EX_CLEAR) ? PG_CLEAR : PG_FILL;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cs && sk_rise && di) nxt = ST_HDR;
            ST_HDR: begin
                if (!cs) begin
                    nxt = ST_IDLE;
                end else if (hdr_done) begin
                    unique case (hdr_op)
                        OP_READ:  nxt = ST_READ;
                        OP_WRITE: nxt = ST_DATA;
                        OP_ERASE: nxt = wen_q ? ST_PROG : ST_HOLD;
                        OP_EXT: begin
                            if (hdr_ext == EX_FILL)       nxt = ST_DATA;
                            else if (hdr_ext == EX_CLEAR) nxt = wen_q ? ST_PROG : ST_HOLD;
                            else                          nxt = ST_HOLD;
                        end
                    endcase
                end
            end
            ST_DATA: begin
                if (!cs)           nxt = ST_IDLE;
                else if (dat_done) nxt = wen_q ? ST_PROG : ST_HOLD;
            end
            ST_READ:  if (!cs) nxt = ST_IDLE;
            ST_HOLD:  if (!cs) nxt = ST_IDLE;
            ST_PROG:  if (!prog_busy) nxt = ST_READY;
            ST_READY: if (cs && sk_rise && di) nxt = ST_HDR;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign prog_start = (nxt == ST_PROG) && (state != ST_PROG);
    assign commit     = (state == ST_PROG) && !prog_busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            cnt_q   <= '0;
            wdat_q  <= '0;
            sr_q    <= '0;
            uaddr_q <= '0;
            cur_q   <= '0;
            pkind   <= PG_WRITE;
            wen_q   <= 1'b0;
            poll_q  <= 1'b0;
            dummy_q <= 1'b0;
        end else if (nxt == ST_HDR && state != ST_HDR) begin
            hdr_q  <= '0;
            cnt_q  <= '0;
            poll_q <= 1'b0;
        end else if (state == ST_HDR && cs && sk_rise) begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + CW'(1);
            if (hdr_done) begin
                cnt_q   <= '0;
                wdat_q  <= '0;
                uaddr_q <= hdr_uaddr;
                cur_q   <= hdr_uaddr;
                pkind   <= hdr_kind;
                if (hdr_op == OP_EXT && hdr_ext == EX_OPEN) wen_q <= 1'b1;
                if (hdr_op == OP_EXT && hdr_ext == EX_LOCK) wen_q <= 1'b0;
                if (hdr_op == OP_READ) begin
                    sr_q    <= rd_align;
                    dummy_q <= 1'b1;
                end
            end
        end else if (state == ST_DATA && cs && sk_rise) begin
            wdat_q <= {wdat_q[DW-2:0], di};
            cnt_q  <= cnt_q + CW'(1);
        end else if (state == ST_READ && cs && sk_rise) begin
            if (dummy_q) begin
                dummy_q <= 1'b0;
            end else if (cnt_q == dat_last) begin
                cnt_q <= '0;
                cur_q <= cur_nx;
                sr_q  <= rd_align;
            end else begin
                sr_q  <= {sr_q[DW-2:0], 1'b0};
                cnt_q <= cnt_q + CW'(1);
            end
        end else if ((state == ST_PROG || state == ST_READY) && !cs) begin
            poll_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        do_oe = 1'b0;
        do_o  = 1'b0;
        unique case (state)
            ST_READ: begin
                do_oe = cs;
                do_o  = dummy_q ? 1'b0 : sr_q[DW-1];
            end
            ST_PROG: begin
                do_oe = cs && poll_q;
                do_o  = 1'b0;
            end
            ST_READY: begin
                do_oe = cs && poll_q;
                do_o  = 1'b1;
            end
            default: begin
                do_oe = 1'b0;
                do_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_eeprom_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      do_o,
    input logic      do_oe,
    input logic      busy,
    input logic      wen,
    input mw_state_t st
);
    AST_CS_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !do_oe);                                            // R11

    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && busy) |-> !do_o);                                 // R10

    AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> (st == ST_READY));                          // R10

    AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wen);                                       // R9

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !do_oe);                                // R9

    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(do_oe) && st == ST_READ) |-> !do_o);                 // R4
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (cs),
    .do_o (do_o),
    .do_oe(do_oe),
    .busy (prog_busy),
    .wen  (wen_q),
    .st   (state)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe;
    int   tests = 0, fails = 0;
    bit   done = 1'b0;
    logic [15:0] w;

    always #2 clk = ~clk;

    mw_eeprom #(.BYTES(256), .WR_CYCLES(64)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .do_o(do_o), .do_oe(do_oe)
    );

    typedef struct packed {
        logic        org;
        logic [8:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 9'h000, 16'hA5C3, 16'hA5C3},
        '{1'b1, 9'h07F, 16'h1234, 16'h1234},
        '{1'b1, 9'h07F, 16'h0F0F, 16'h0F0F},
        '{1'b1, 9'h085, 16'hBEEF, 16'hBEEF},
        '{1'b0, 9'h1FF, 16'h00C3, 16'h00C3},
        '{1'b0, 9'h013, 16'h007E, 16'h007E}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_sk(input logic b);
        @(negedge clk); di = b; sk = 1'b0;
        repeat (3) @(negedge clk);
        sk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic begin_cmd();
        @(negedge clk); cs = 1'b0; sk = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_cmd();
        @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [8:0] addr);
        int aw;
        aw = org ? 8 : 9;
        clk_sk(1'b1);
        clk_sk(op[1]);
        clk_sk(op[0]);
        for (int i = aw - 1; i >= 0; i--) clk_sk(addr[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = (org ? 15 : 7); i >= 0; i--) clk_sk(d[i]);
    endtask

    task automatic wait_ready();
        int n;
        @(negedge clk); cs = 1'b1;
        n = 0;
        while (!(do_oe && do_o) && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) check("R10 ready never seen", 0, 1);
        @(negedge clk); cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ext(input logic [1:0] sel);
        begin_cmd();
        hdr(2'b00, org ? {1'b0, sel, 6'b0} : {sel, 7'b0});
        end_cmd();
    endtask

    task automatic write_word(input logic [8:0] addr, input logic [15:0] d);
        begin_cmd();
        hdr(2'b01, addr);
        send_data(d);
        end_cmd();
        wait_ready();
    endtask

    task automatic read_begin(input logic [8:0] addr);
        begin_cmd();
        hdr(2'b10, addr);
        check("R4 dummy bit {oe,do}", {do_oe, do_o}, 2'b10);
    endtask

    task automatic read_next(output logic [15:0] v);
        v = '0;
        for (int i = 0; i < (org ? 16 : 8); i++) begin
            clk_sk(1'b0);
            v = {v[14:0], do_o};
        end
    endtask

    task automatic read_one(input logic [8:0] addr, output logic [15:0] v);
        read_begin(addr);
        read_next(v);
        end_cmd();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1 do_oe after reset", do_oe, 0);
        cs = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 do_oe idle with cs high", do_oe, 0);
        cs = 1'b0;
        read_one(9'h003, w);
        check("R1 erased content", w, 16'hFFFF);

        // R9: locked after reset
        begin_cmd(); hdr(2'b01, 9'h003); send_data(16'h0000); end_cmd();
        begin_cmd();
        check("R9 no busy when locked", do_oe, 0);
        end_cmd();
        read_one(9'h003, w);
        check("R9 locked write ignored", w, 16'hFFFF);

        // table: write then read back (R6, R3)
        ext(2'b11);
        for (int i = 0; i < 6; i++) begin
            org = VEC[i].org;
            write_word(VEC[i].addr, VEC[i].data);
            read_one(VEC[i].addr, w);
            check($sformatf("R6 vector %0d readback", i), w, VEC[i].exp);
        end

        // R3: x16 top address bit ignored
        org = 1'b1;
        read_one(9'h005, w);
        check("R3 address bit 7 ignored", w, 16'hBEEF);

        // R3: byte to word layout
        org = 1'b0;
        write_word(9'h000, 16'h0012);
        write_word(9'h001, 16'h0034);
        org = 1'b1;
        read_one(9'h000, w);
        check("R3 word from byte pair", w, 16'h1234);

        // R10: busy then ready
        begin_cmd(); hdr(2'b01, 9'h010); send_data(16'h5555); end_cmd();
        @(negedge clk); cs = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 busy status {oe,do}", {do_oe, do_o}, 2'b10);
        repeat (80) @(negedge clk);
        check("R10 ready status {oe,do}", {do_oe, do_o}, 2'b11);
        end_cmd();
        read_one(9'h010, w);
        check("R10 programmed value", w, 16'h5555);

        // R7: erase
        begin_cmd(); hdr(2'b11, 9'h010); end_cmd();
        wait_ready();
        read_one(9'h010, w);
        check("R7 erase gives ones", w, 16'hFFFF);

        // R9: disable locks again
        ext(2'b00);
        begin_cmd(); hdr(2'b01, 9'h010); send_data(16'h0000); end_cmd();
        begin_cmd();
        check("R9 no busy after disable", do_oe, 0);
        end_cmd();
        read_one(9'h010, w);
        check("R9 write after disable ignored", w, 16'hFFFF);
        ext(2'b11);

        // R11: abort mid data
        begin_cmd(); hdr(2'b01, 9'h020);
        for (int i = 0; i < 8; i++) clk_sk(1'b0);
        end_cmd();
        check("R11 do released on cs low", do_oe, 0);
        begin_cmd();
        check("R11 no busy after abort", do_oe, 0);
        end_cmd();
        read_one(9'h020, w);
        check("R11 aborted write no effect", w, 16'hFFFF);

        // R11: cs low during read releases do
        read_begin(9'h000);
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        check("R11 read released", do_oe, 0);
        repeat (2) @(negedge clk);

        // R2: leading zeros before start bit
        begin_cmd();
        clk_sk(1'b0); clk_sk(1'b0); clk_sk(1'b0);
        hdr(2'b10, 9'h000);
        check("R2 dummy after zeros", {do_oe, do_o}, 2'b10);
        read_next(w);
        end_cmd();
        check("R2 leading zeros ignored", w, 16'h1234);

        // R5: sequential read with wrap, x16
        write_word(9'h07F, 16'h1111);
        write_word(9'h000, 16'h2222);
        read_begin(9'h07F);
        read_next(w);
        check("R5 x16 first word", w, 16'h1111);
        read_next(w);
        check("R5 x16 wrapped word", w, 16'h2222);
        end_cmd();

        // R5: sequential read with wrap, x8
        org = 1'b0;
        write_word(9'h0FF, 16'h00AB);
        write_word(9'h000, 16'h00CD);
        read_begin(9'h0FF);
        read_next(w);
        check("R5 x8 first byte", w, 16'h00AB);
        read_next(w);
        check("R5 x8 wrapped byte", w, 16'h00CD);
        end_cmd();

        // R8: write-all
        org = 1'b1;
        begin_cmd(); hdr(2'b00, 9'h040); send_data(16'h3C5A); end_cmd();
        wait_ready();
        read_one(9'h000, w);
        check("R8 write-all word 0", w, 16'h3C5A);
        read_one(9'h040, w);
        check("R8 write-all word 0x40", w, 16'h3C5A);
        org = 1'b0;
        read_one(9'h001, w);
        check("R8 write-all low byte", w, 16'h005A);

        // R8: erase-all
        org = 1'b1;
        begin_cmd(); hdr(2'b00, 9'h080); end_cmd();
        wait_ready();
        read_one(9'h033, w);
        check("R8 erase-all gives ones", w, 16'hFFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule